// File: doc/BRIEF.md
# Temperature Alarm Event Logic

This block turns a stream of temperature samples into three status flags and one event output. Each sample is a 13-bit two's-complement value in steps of 0.125 °C, marked by a one-cycle valid strobe. It is compared against three programmed thresholds: a high window edge, a low window edge and a critical level. Each threshold is held in 0.25 °C steps. A flag rises as soon as the temperature passes its threshold in the unsafe direction. It returns only after the temperature has moved back past the threshold by a selectable hysteresis margin.

The event output follows the flags in comparator mode. In latched mode it captures window crossings and holds them until software pulses a clear input, while the critical flag still passes straight through. A critical-only option masks the window flags from the output. A polarity bit chooses the active level. Sticky lock bits freeze the thresholds and the event controls. A shutdown bit stops sample processing, and a sleep bit chooses whether the output freezes or releases while shut down. The output is a logic level; the open-drain pad is outside the block.

Top module: `temp_alarm_event`

## Requirements
- R1: After reset all three flags read 0, every threshold and control field is 0, and `event_pin` is 1: the output is deasserted with the active-low polarity.
- R2: `stat_flags[1]` (above window) sets on an accepted sample strictly greater than twice the high threshold in sample units. It clears only on a sample below that level minus the hysteresis, and otherwise holds. The hysteresis code gives 0, 12, 24 or 48 sample units, that is 0, 1.5, 3 or 6 °C.
- R3: `stat_flags[0]` (below window) sets on an accepted sample below twice the low threshold minus the hysteresis. It clears on a sample strictly above twice the low threshold, and otherwise holds.
- R4: `stat_flags[2]` (critical) follows the rule of R2 against the critical threshold.
- R5: Flags change only on the clock edge that accepts a valid sample, and are visible from that edge on. A sample with the strobe low has no effect. Threshold writes use `lim_sel` 0 for high, 1 for low and 2 for critical, in 0.25 °C two's-complement steps.
- R6: In comparator mode (mode bit 0) with the enable bit 1, the event is active while any flag is set. With the enable bit 0 the event is never active.
- R7: With the critical-only bit set, the event depends on the critical flag alone.
- R8: In latched mode (mode bit 1), a setting edge of the above or below flag latches the event until an `irq_clear` pulse. The critical flag drives the event directly. Entering latched mode drops an event that only a window flag caused.
- R9: `event_pin` equals the event state when the polarity bit is 1 and its inverse when it is 0. A polarity write takes effect on the edge that stores it, also during shutdown.
- R10: `cfg_data` bits are: [0] enable, [1] mode, [2] polarity, [3] critical-only, [5:4] hysteresis code, [6] sleep, [7] shutdown, [8] window lock, [9] critical lock. Lock bits stay set until reset. The window lock ignores writes to the high and low thresholds. The critical lock ignores writes to the critical threshold. Either lock ignores writes to bits [5:0].
- R11: Shutdown cannot be entered while either lock is set, but it can always be left. While shut down, samples are ignored.
- R12: During shutdown the event keeps its last value if the sleep bit is 0, and is deasserted if it is 1.
- R13: After shutdown is left, the event stays deasserted until the first sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| samp_valid | input | 1 | One-cycle strobe marking a new sample |
| samp_temp | input | TW (13) | Sample, two's complement, 0.125 °C per step |
| lim_wr | input | 1 | Threshold write strobe |
| lim_sel | input | 2 | Threshold select: 0 high, 1 low, 2 critical |
| lim_data | input | TW-1 (12) | Threshold value, two's complement, 0.25 °C per step |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 10 | Control word, fields as in R10 |
| irq_clear | input | 1 | Releases a latched event |
| stat_flags | output | 3 | {critical, above window, below window} |
| event_pin | output | 1 | Event level after polarity |

## Verification
A table of samples walks the temperature up through the high and critical thresholds, back down through their hysteresis bands, and below the low threshold. It includes values exactly on each threshold and on each threshold minus the margin, which separates strict from inclusive comparisons. Further runs repeat the high-threshold walk with each of the other hysteresis codes, so that a wrong margin shows up as a flag clearing one step early or late. Directed sequences cross the window both ways in latched mode, with and without a clear, and show that a critical level survives a clear. They then try writes that the locks should ignore and check the result through later samples. Shutdown is driven through both sleep settings and a polarity flip, and the first sample after wake-up is checked.

// File: rtl/tae_pkg.sv
package tae_pkg;

  typedef enum logic {
    EV_COMPARE = 1'b0,
    EV_LATCH   = 1'b1
  } ev_mode_e;

  // Packed MSB first: crit_lock is bit 9, enable is bit 0.
  typedef struct packed {
    logic       crit_lock;
    logic       win_lock;
    logic       shutdown;
    logic       sleep_off;
    logic [1:0] hyst;
    logic       crit_only;
    logic       pol_high;
    ev_mode_e   mode;
    logic       enable;
  } cfg_t;

  localparam int CFG_W     = $bits(cfg_t);
  localparam int LIM_UPPER = 0;
  localparam int LIM_LOWER = 1;
  localparam int LIM_CRIT  = 2;

  // Hysteresis margin in sample steps of 0.125 degC.
  function automatic int unsigned hyst_steps(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 12;
      2'd2:    return 24;
      default: return 48;
    endcase
  endfunction

endpackage

// File: rtl/tae_regs.sv
module tae_regs
  import tae_pkg::*;
#(
  parameter int LW   = 12,
  parameter int NLIM = 3,
  localparam int SELW = $clog2(NLIM)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lim_wr,
  input  logic [SELW-1:0]           lim_sel,
  input  logic [LW-1:0]             lim_data,
  input  logic                      cfg_wr,
  input  cfg_t                      cfg_in,
  output logic [NLIM-1:0][LW-1:0]   lim_q,
  output cfg_t                      cfg_q,
  output logic                      lock_any
);

  assign lock_any = cfg_q.crit_lock | cfg_q.win_lock;

  // One storage register per threshold; the lock that guards it is picked by index.
  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    logic          frozen;
    logic [LW-1:0] val_q;
    assign frozen = (i == LIM_CRIT) ? cfg_q.crit_lock : cfg_q.win_lock;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= '0;
      else if (lim_wr && (lim_sel == SELW'(i)) && !frozen)
        val_q <= lim_data;
    end
    assign lim_q[i] = val_q;
  end

  cfg_t cfg_nx;

  always_comb begin
    cfg_nx = cfg_q;
    if (cfg_wr) begin
      cfg_nx.crit_lock = cfg_q.crit_lock | cfg_in.crit_lock;
      cfg_nx.win_lock  = cfg_q.win_lock  | cfg_in.win_lock;
      cfg_nx.sleep_off = cfg_in.sleep_off;
      cfg_nx.shutdown  = cfg_in.shutdown & (cfg_q.shutdown | ~lock_any);
      if (!lock_any) begin
        cfg_nx.enable    = cfg_in.enable;
        cfg_nx.mode      = cfg_in.mode;
        cfg_nx.pol_high  = cfg_in.pol_high;
        cfg_nx.crit_only = cfg_in.crit_only;
        cfg_nx.hyst      = cfg_in.hyst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nx;
  end

endmodule

// File: rtl/tae_cmp.sv
module tae_cmp
  import tae_pkg::*;
#(
  parameter int   TW   = 13,
  parameter logic INIT = 1'b0,
  localparam int  LW   = TW - 1,
  localparam int  XW   = TW + 2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [TW-1:0] temp,
  input  logic [LW-1:0] limit,
  input  logic [1:0]    hyst,
  output logic          state,
  output logic          rise,
  output logic          fall
);

  logic signed [XW-1:0] t_x, hi_x, lo_x;
  logic                 over_hi, under_lo;

  // Threshold in 0.25 degC becomes sample units by one left shift.
  assign t_x  = {{2{temp[TW-1]}}, temp};
  assign hi_x = {{2{limit[LW-1]}}, limit, 1'b0};
  assign lo_x = hi_x - XW'(hyst_steps(hyst));

  assign over_hi  = t_x > hi_x;
  assign under_lo = t_x < lo_x;

  assign rise = take & over_hi  & ~state;
  assign fall = take & under_lo &  state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= INIT;
    else if (rise) state <= 1'b1;
    else if (fall) state <= 1'b0;
  end

endmodule

// File: rtl/tae_event.sv
module tae_event
  import tae_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_q,
  input  logic take,
  input  logic crit_f,
  input  logic win_f,
  input  logic win_set,
  input  logic irq_clear,
  output logic latch_q,
  output logic awake_q,
  output logic evt_active,
  output logic event_pin
);

  logic raw, live, held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               latch_q <= 1'b0;
    else if (cfg_q.mode != EV_LATCH)          latch_q <= 1'b0;
    else if (win_set && !cfg_q.crit_only)     latch_q <= 1'b1;
    else if (irq_clear)                       latch_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              awake_q <= 1'b0;
    else if (cfg_q.shutdown) awake_q <= 1'b0;
    else if (take)           awake_q <= 1'b1;
  end

  always_comb begin
    if (cfg_q.crit_only)              raw = crit_f;
    else if (cfg_q.mode == EV_LATCH)  raw = crit_f | latch_q;
    else                              raw = crit_f | win_f;
  end

  assign live = cfg_q.enable & raw & awake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               held_q <= 1'b0;
    else if (!cfg_q.shutdown) held_q <= live;
  end

  assign evt_active = cfg_q.shutdown ? (~cfg_q.sleep_off & held_q) : live;
  assign event_pin  = cfg_q.pol_high ? evt_active : ~evt_active;

endmodule

// File: rtl/temp_alarm_event.sv
module temp_alarm_event
  import tae_pkg::*;
#(
  parameter int  TW   = 13,
  localparam int LW   = TW - 1,
  localparam int NLIM = 3,
  localparam int SELW = $clog2(NLIM)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_valid,
  input  logic [TW-1:0]    samp_temp,
  input  logic             lim_wr,
  input  logic [SELW-1:0]  lim_sel,
  input  logic [LW-1:0]    lim_data,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             irq_clear,
  output logic [2:0]       stat_flags,
  output logic             event_pin
);

  logic [NLIM-1:0][LW-1:0] lim_q;
  cfg_t                    cfg_q;
  logic                    lock_any;
  logic                    take;
  logic [NLIM-1:0]         state_v, rise_v, fall_v;
  logic                    crit_f, above_f, below_f, win_set;
  logic                    latch_q, awake_q, evt_active;

  tae_regs #(.LW(LW), .NLIM(NLIM)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .lim_wr(lim_wr), .lim_sel(lim_sel), .lim_data(lim_data),
    .cfg_wr(cfg_wr), .cfg_in(cfg_t'(cfg_data)),
    .lim_q(lim_q), .cfg_q(cfg_q), .lock_any(lock_any)
  );

  assign take = samp_valid & ~cfg_q.shutdown;

  // The low-edge comparator starts in its "above" state so the below flag resets to 0.
  for (genvar i = 0; i < NLIM; i++) begin : g_cmp
    tae_cmp #(.TW(TW), .INIT(i == LIM_LOWER)) u_cmp (
      .clk(clk), .rst_n(rst_n), .take(take),
      .temp(samp_temp), .limit(lim_q[i]), .hyst(cfg_q.hyst),
      .state(state_v[i]), .rise(rise_v[i]), .fall(fall_v[i])
    );
  end

  assign crit_f  = state_v[LIM_CRIT];
  assign above_f = state_v[LIM_UPPER];
  assign below_f = ~state_v[LIM_LOWER];
  assign win_set = rise_v[LIM_UPPER] | fall_v[LIM_LOWER];

  tae_event u_evt (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .take(take),
    .crit_f(crit_f), .win_f(above_f | below_f), .win_set(win_set),
    .irq_clear(irq_clear), .latch_q(latch_q), .awake_q(awake_q),
    .evt_active(evt_active), .event_pin(event_pin)
  );

  assign stat_flags = {crit_f, above_f, below_f};

endmodule

// File: rtl/tae_checker.sv
module tae_checker
  import tae_pkg::*;
#(
  parameter int TW   = 13,
  parameter int LW   = 12,
  parameter int NLIM = 3,
  localparam int SELW = $clog2(NLIM)
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    take,
  input logic [TW-1:0]           samp_temp,
  input logic                    lim_wr,
  input logic [SELW-1:0]         lim_sel,
  input logic                    cfg_wr,
  input logic                    irq_clear,
  input logic [NLIM-1:0][LW-1:0] lim_q,
  input cfg_t                    cfg_q,
  input logic                    lock_any,
  input logic [NLIM-1:0]         state_v,
  input logic [NLIM-1:0]         rise_v,
  input logic [NLIM-1:0]         fall_v,
  input logic                    latch_q,
  input logic                    awake_q,
  input logic                    evt_active,
  input logic [2:0]              stat_flags,
  input logic                    event_pin
);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(stat_flags)); // R5

  AST_ABOVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    take && ($signed(samp_temp) > $signed({lim_q[LIM_UPPER], 1'b0})) |=> stat_flags[1]); // R2

  AST_CRIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    take && ($signed(samp_temp) > $signed({lim_q[LIM_CRIT], 1'b0})) |=> stat_flags[2]); // R4

  for (genvar i = 0; i < NLIM; i++) begin : g_edge
    AST_RISE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      rise_v[i] |=> state_v[i]); // R3
    AST_FALL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      fall_v[i] |=> !state_v[i]); // R3
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q && !irq_clear && !cfg_wr && cfg_q.mode == EV_LATCH |=> latch_q); // R8

  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q.pol_high) && $stable(evt_active) |-> event_pin != $past(event_pin)); // R9

  AST_CRIT_LIM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.crit_lock && lim_wr && lim_sel == SELW'(LIM_CRIT) |=> $stable(lim_q[LIM_CRIT])); // R10

  AST_NO_SD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_any && !cfg_q.shutdown |=> !cfg_q.shutdown); // R11

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.shutdown && $past(cfg_q.shutdown) && !cfg_q.sleep_off && !$past(cfg_q.sleep_off)
      |-> $stable(evt_active)); // R12

  AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.shutdown && cfg_q.sleep_off |-> !evt_active); // R12

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !awake_q |-> !evt_active || cfg_q.shutdown); // R13

endmodule

bind temp_alarm_event tae_checker #(.TW(TW), .LW(LW), .NLIM(NLIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .samp_temp(samp_temp),
  .lim_wr(lim_wr), .lim_sel(lim_sel), .cfg_wr(cfg_wr), .irq_clear(irq_clear),
  .lim_q(lim_q), .cfg_q(cfg_q), .lock_any(lock_any),
  .state_v(state_v), .rise_v(rise_v), .fall_v(fall_v),
  .latch_q(latch_q), .awake_q(awake_q), .evt_active(evt_active),
  .stat_flags(stat_flags), .event_pin(event_pin)
);

// File: tb/temp_alarm_event_test.sv
`timescale 1ns/1ps
module temp_alarm_event_test;

  localparam int TW = 13;
  localparam int LW = TW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_valid = 1'b0;
  logic [TW-1:0] samp_temp = '0;
  logic          lim_wr = 1'b0;
  logic [1:0]    lim_sel = '0;
  logic [LW-1:0] lim_data = '0;
  logic          cfg_wr = 1'b0;
  logic [9:0]    cfg_data = '0;
  logic          irq_clear = 1'b0;
  logic [2:0]    stat_flags;
  logic          event_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  temp_alarm_event #(.TW(TW)) uut (.*);

  // {sample[12:0], flags {crit,above,below}, pin}; high 80 C, low 10 C, crit 90 C, margin 1.5 C
  localparam logic [16:0] VEC [15] = '{
    {13'd400,  3'b000, 1'b0}, {13'd640,  3'b000, 1'b0}, {13'd641,  3'b010, 1'b1},
    {13'd630,  3'b010, 1'b1}, {13'd628,  3'b010, 1'b1}, {13'd627,  3'b000, 1'b0},
    {13'd721,  3'b110, 1'b1}, {13'd709,  3'b110, 1'b1}, {13'd707,  3'b010, 1'b1},
    {13'd80,   3'b000, 1'b0}, {13'd68,   3'b000, 1'b0}, {13'd67,   3'b001, 1'b1},
    {13'd79,   3'b001, 1'b1}, {13'd81,   3'b000, 1'b0}, {13'h1E70, 3'b001, 1'b1}
  };

  function automatic logic [9:0] mk_cfg(input bit en, input bit md, input bit pol, input bit co,
                                        input logic [1:0] hy, input bit slp, input bit sd,
                                        input bit wl, input bit cl);
    return {cl, wl, sd, slp, hy, co, pol, md, en};
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {flags,pin} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [9:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr_lim(input logic [1:0] s, input logic [LW-1:0] v);
    @(negedge clk); lim_wr = 1'b1; lim_sel = s; lim_data = v;
    @(negedge clk); lim_wr = 1'b0;
  endtask

  task automatic sample(input logic [TW-1:0] t);
    @(negedge clk); samp_valid = 1'b1; samp_temp = t;
    @(negedge clk); samp_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic setup(input logic [1:0] hy);
    do_reset();
    wr_lim(2'd0, 12'd320);
    wr_lim(2'd1, 12'd40);
    wr_lim(2'd2, 12'd360);
    wr_cfg(mk_cfg(1, 0, 1, 0, hy, 0, 0, 0, 0));
  endtask

  initial begin
    do_reset();
    chk("R1 reset", {stat_flags, event_pin}, 4'b0001);

    // Table walk: comparator mode, active-high, margin code 1
    setup(2'd1);
    for (int i = 0; i < 15; i++) begin
      sample(VEC[i][16:4]);
      chk($sformatf("R2/R3/R4/R6 vector %0d", i), {stat_flags, event_pin}, VEC[i][3:0]);
    end

    // Margin code 0 and code 2 and code 3
    setup(2'd0);
    sample(13'd641); chk("R2 code0 set", {stat_flags, event_pin}, 4'b0101);
    sample(13'd639); chk("R2 code0 clear", {stat_flags, event_pin}, 4'b0000);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd2, 0, 0, 0, 0));
    sample(13'd641); chk("R2 code2 set", {stat_flags, event_pin}, 4'b0101);
    sample(13'd616); chk("R2 code2 hold", {stat_flags, event_pin}, 4'b0101);
    sample(13'd615); chk("R2 code2 clear", {stat_flags, event_pin}, 4'b0000);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd3, 0, 0, 0, 0));
    sample(13'd641); chk("R2 code3 set", {stat_flags, event_pin}, 4'b0101);
    sample(13'd592); chk("R2 code3 hold", {stat_flags, event_pin}, 4'b0101);
    sample(13'd591); chk("R2 code3 clear", {stat_flags, event_pin}, 4'b0000);

    // R5: no strobe, no change; R6 enable off; R9 polarity; R7 critical-only
    setup(2'd1);
    sample(13'd641);
    @(negedge clk); samp_temp = 13'd0;
    repeat (3) @(negedge clk);
    chk("R5 no strobe", {stat_flags, event_pin}, 4'b0101);
    wr_cfg(mk_cfg(0, 0, 1, 0, 2'd1, 0, 0, 0, 0));
    chk("R6 disabled", {stat_flags, event_pin}, 4'b0100);
    wr_cfg(mk_cfg(1, 0, 0, 0, 2'd1, 0, 0, 0, 0));
    chk("R9 active low", {stat_flags, event_pin}, 4'b0100);
    wr_cfg(mk_cfg(1, 0, 1, 1, 2'd1, 0, 0, 0, 0));
    chk("R7 window masked", {stat_flags, event_pin}, 4'b0100);
    sample(13'd721); chk("R7 critical passes", {stat_flags, event_pin}, 4'b1101);

    // R8 latched mode
    setup(2'd1);
    sample(13'd641); chk("R8 comparator before", {stat_flags, event_pin}, 4'b0101);
    wr_cfg(mk_cfg(1, 1, 1, 0, 2'd1, 0, 0, 0, 0));
    chk("R8 switch drops", {stat_flags, event_pin}, 4'b0100);
    sample(13'd627);
    sample(13'd641); chk("R8 latch on rise", {stat_flags, event_pin}, 4'b0101);
    sample(13'd627); chk("R8 latch holds", {stat_flags, event_pin}, 4'b0001);
    pulse_clear();   chk("R8 clear", {stat_flags, event_pin}, 4'b0000);
    sample(13'd67);  chk("R8 below latches", {stat_flags, event_pin}, 4'b0011);
    pulse_clear();   chk("R8 below clear", {stat_flags, event_pin}, 4'b0010);
    sample(13'd400);
    sample(13'd721); chk("R8 critical", {stat_flags, event_pin}, 4'b1101);
    pulse_clear();   chk("R8 critical survives clear", {stat_flags, event_pin}, 4'b1101);
    sample(13'd600); chk("R8 critical gone", {stat_flags, event_pin}, 4'b0000);

    // R10 locks, R11 shutdown refused while locked
    setup(2'd1);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd1, 0, 0, 1, 1));
    wr_lim(2'd0, 12'd400);
    wr_lim(2'd2, 12'd400);
    sample(13'd700); chk("R10 high frozen", {stat_flags, event_pin}, 4'b0101);
    wr_cfg(mk_cfg(1, 0, 0, 0, 2'd1, 0, 0, 0, 0));
    chk("R10 polarity frozen", {stat_flags, event_pin}, 4'b0101);
    sample(13'd721); chk("R10 critical frozen", {stat_flags, event_pin}, 4'b1101);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd1, 0, 1, 1, 1));
    sample(13'd600); chk("R11 shutdown refused", {stat_flags, event_pin}, 4'b0000);

    // R11/R12/R13 shutdown
    setup(2'd1);
    sample(13'd641);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd1, 0, 1, 0, 0));
    chk("R12 frozen", {stat_flags, event_pin}, 4'b0101);
    sample(13'd400); chk("R11 sample ignored", {stat_flags, event_pin}, 4'b0101);
    wr_cfg(mk_cfg(1, 0, 0, 0, 2'd1, 0, 1, 0, 0));
    chk("R9 polarity in shutdown", {stat_flags, event_pin}, 4'b0100);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd1, 1, 1, 0, 0));
    chk("R12 released", {stat_flags, event_pin}, 4'b0100);
    wr_cfg(mk_cfg(1, 0, 1, 0, 2'd1, 0, 0, 0, 0));
    chk("R13 quiet after wake", {stat_flags, event_pin}, 4'b0100);
    sample(13'd641); chk("R13 first sample", {stat_flags, event_pin}, 4'b0101);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule